// File: doc/BRIEF.md
# Protected Flash Block-Erase Controller

This controller lets a small processor erase one 1024-byte block of on-chip program flash through three memory-mapped registers. The registers are a 22-bit byte pointer, a control register and an unlock key register. The upper pointer bits pick the block. The low ten bits play no part, because the block is the smallest unit that can be erased and single words cannot be erased.

Software sets the pointer and sets the write-enable and erase-select bits. It then writes the two-byte key, 55h followed by AAh, and sets the start bit. Only then does the erase begin. A start attempt uses up the unlock whether or not it succeeds, so every erase needs a fresh key sequence.

While the erase runs, the controller holds the CPU stall output high. It also drives a block-clear request, with the block index, to the behavioural flash array, which sets every byte of that block to FFh. An internal cycle timer ends the operation and releases the stall. All pins are plain control and status pins: no data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, the pointer, control and key registers read 0, and `cpu_stall_o` and `fl_erase_o` are low.
- R2: Register addresses are 0 for the pointer (bits 21:0 read/write, upper bits read 0), 1 for control and 2 for the key register (always reads 0). Control bits are: bit0 start/busy, bit1 write-enable, bit2 erase-select, bit3 error (read-only).
- R3: Only bits 7:0 of a key write are compared. A 55h write followed directly by an AAh write arms the controller. Any other key write, including a second 55h or any key write while armed, returns the sequence to its initial state.
- R4: A control write with bit0 = 1 begins an erase only when the controller is armed and the written write-enable and erase-select bits are both 1. Otherwise no erase occurs.
- R5: Every control write with bit0 = 1 disarms the controller, whether or not an erase starts.
- R6: Once an erase starts, `cpu_stall_o` rises on the cycle after the start write and stays high for exactly ERASE_CYCLES cycles. The start bit reads 1 during that time and reads 0 after it.
- R7: `fl_erase_o` is high during the same window. `fl_block_o` then equals pointer bits 21:10, so pointer bits 9:0 have no effect on which block is cleared.
- R8: A start attempt with write-enable 0 sets the error bit and starts no erase. A start attempt with write-enable 1 clears the error bit.
- R9: While the erase runs, all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 pointer, 1 control, 2 key) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| cpu_stall_o | output | 1 | Holds the CPU while an erase runs |
| fl_erase_o | output | 1 | Block-clear request to the flash array |
| fl_block_o | output | 12 | Index of the block being cleared |

## Verification
The embedded assertions check the following on every cycle:
- An erase can only begin from an armed controller and a qualifying control write.
- The armed state is only reached through the ordered 55h/AAh pair, and every start attempt disarms it.
- The timer keeps the stall high until its count runs out.
- The pointer stays unchanged while busy.
- Raising the error flag never coincides with an erase.

The bench scenarios show what the assertions cannot:
- the exact stall length;
- the block index derived from pointers with different low bits;
- rejection of the bad key orders (AAh first, a repeated 55h, a trailing 55h);
- the one-attempt consumption of the unlock;
- the setting and later clearing of the error flag.

A cycle-by-cycle reference model additionally compares stall, block index and read data on every clock.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } key_state_e;

  localparam logic [1:0] RA_PTR  = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_KEY  = 2'd2;

  localparam int CB_START = 0;
  localparam int CB_WEN   = 1;
  localparam int CB_ESEL  = 2;
  localparam int CB_ERR   = 3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/erase_key_fsm.sv
module erase_key_fsm
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       consume,
  output logic       armed
);
  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KEY_IDLE;
    end else if (consume) begin
      state_q <= KEY_IDLE;
    end else if (key_wr) begin
      if (state_q == KEY_IDLE && key_data == KEY_FIRST)
        state_q <= KEY_HALF;
      else if (state_q == KEY_HALF && key_data == KEY_SECOND)
        state_q <= KEY_ARMED;
      else
        state_q <= KEY_IDLE;
    end
  end

  assign armed = (state_q == KEY_ARMED);

  // R3
  arm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_ARMED && $past(state_q) != KEY_ARMED) |->
      $past(state_q == KEY_HALF && key_wr && key_data == KEY_SECOND));

  // R5
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (state_q != KEY_ARMED));
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign busy = busy_q;

  // R6
  busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int PTR_W        = 22,
  parameter int BLK_LSB      = 10,
  parameter int DATA_W       = 32,
  parameter int ERASE_CYCLES = 16,
  localparam int BLK_W       = PTR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_stall_o,
  output logic              fl_erase_o,
  output logic [BLK_W-1:0]  fl_block_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             wen_q, esel_q, err_q;
  logic             busy, armed;
  logic             wr_ok, ctrl_wr, key_wr, attempt, go;
  logic             unused_bits;

  assign unused_bits = ^bus_wdata[DATA_W-1:PTR_W];

  assign wr_ok   = bus_wr && !busy;
  assign ctrl_wr = wr_ok && (bus_addr == RA_CTRL);
  assign key_wr  = wr_ok && (bus_addr == RA_KEY);
  assign attempt = ctrl_wr && bus_wdata[CB_START];
  assign go      = attempt && armed && bus_wdata[CB_WEN] && bus_wdata[CB_ESEL];

  erase_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata[7:0]),
    .consume  (attempt),
    .armed    (armed)
  );

  erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wen_q  <= 1'b0;
      esel_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok && bus_addr == RA_PTR) ptr_q <= bus_wdata[PTR_W-1:0];
      if (ctrl_wr) begin
        wen_q  <= bus_wdata[CB_WEN];
        esel_q <= bus_wdata[CB_ESEL];
        if (attempt) err_q <= !bus_wdata[CB_WEN];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_PTR:  bus_rdata[PTR_W-1:0] = ptr_q;
      RA_CTRL: begin
        bus_rdata[CB_START] = busy;
        bus_rdata[CB_WEN]   = wen_q;
        bus_rdata[CB_ESEL]  = esel_q;
        bus_rdata[CB_ERR]   = err_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign cpu_stall_o = busy;
  assign fl_erase_o  = busy;
  assign fl_block_o  = ptr_q[PTR_W-1:BLK_LSB];

  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed && bus_wr && bus_addr == RA_CTRL &&
                          bus_wdata[CB_START] && bus_wdata[CB_WEN] && bus_wdata[CB_ESEL]));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr_q));

  // R8
  err_no_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !busy);

  // R7
  block_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fl_block_o));
endmodule

// File: tb/flash_erase_ctrl_bench.sv
module flash_erase_ctrl_bench;
  localparam int CYC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_stall_o, fl_erase_o;
  logic [11:0] fl_block_o;

  int total = 0;
  int fails = 0;

  // reference model state
  int unsigned m_ptr = 0;
  bit m_wen = 0, m_esel = 0, m_err = 0;
  int m_key = 0;
  int m_left = 0;

  always #10 clk = ~clk;

  flash_erase_ctrl u_flash_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stall_o(cpu_stall_o),
    .fl_erase_o(fl_erase_o), .fl_block_o(fl_block_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return m_ptr;
      2'd1: return {28'd0, m_err, m_esel, m_wen, (m_left > 0)};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_wen = 0; m_esel = 0; m_err = 0; m_key = 0; m_left = 0;
    end else if (m_left > 0) begin
      m_left--;
    end else if (bus_wr) begin
      case (bus_addr)
        2'd0: m_ptr = bus_wdata & 32'h003F_FFFF;
        2'd1: begin
          m_wen = bus_wdata[1]; m_esel = bus_wdata[2];
          if (bus_wdata[0]) begin
            if (!m_wen) m_err = 1;
            else begin
              m_err = 0;
              if (m_esel && m_key == 2) m_left = CYC;
            end
            m_key = 0;
          end
        end
        2'd2: begin
          if (m_key == 0 && bus_wdata[7:0] == 8'h55) m_key = 1;
          else if (m_key == 1 && bus_wdata[7:0] == 8'hAA) m_key = 2;
          else m_key = 0;
        end
        default: ;
      endcase
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check("R6 model stall", {31'd0, cpu_stall_o}, {31'd0, (m_left > 0)});
      check("R7 model erase", {31'd0, fl_erase_o}, {31'd0, (m_left > 0)});
      if (m_left > 0) check("R7 model block", {20'd0, fl_block_o}, m_ptr >> 10);
      check("R2 model rdata", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(2'd2, 32'h55);
    wr(2'd2, 32'hAA);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, d); check("R1 ptr", d, 0);
    rd(2'd1, d); check("R1 ctrl", d, 0);
    check("R1 stall", {31'd0, cpu_stall_o}, 0);
    check("R1 erase", {31'd0, fl_erase_o}, 0);
    // R2 map
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R2 ptr mask", d, 32'h003F_FFFF);
    wr(2'd2, 32'h12);
    rd(2'd2, d); check("R2 key reads zero", d, 0);
    // R6 R7 full erase
    wr(2'd0, 32'h0012_3456);
    wr(2'd1, 32'h6);
    unlock();
    wr(2'd1, 32'h7);
    check("R7 block index", {20'd0, fl_block_o}, 32'h48D);
    rd(2'd1, d); check("R6 start reads busy", d[0], 1);
    n = 0;
    while (cpu_stall_o && n < 1000) begin n++; @(negedge clk); end
    check("R6 stall length", n, CYC);
    rd(2'd1, d); check("R6 start clears", d, 32'h6);
    // R7 low pointer bits ignored
    wr(2'd0, 32'h0012_33FF);
    unlock();
    wr(2'd1, 32'h7);
    check("R7 low bits ignored", {20'd0, fl_block_o}, 32'h48C);
    // R9 writes ignored while busy
    wr(2'd0, 32'h0000_0400);
    wr(2'd1, 32'h0);
    rd(2'd0, d); check("R9 ptr held", d, 32'h0012_33FF);
    rd(2'd1, d); check("R9 ctrl held", d, 32'h7);
    idle(CYC + 2);
    check("R6 stall released", {31'd0, cpu_stall_o}, 0);
    // R4 start without unlock
    wr(2'd1, 32'h7);
    check("R4 no unlock", {31'd0, cpu_stall_o}, 0);
    // R3 wrong orders
    wr(2'd2, 32'hAA); wr(2'd2, 32'h55); wr(2'd1, 32'h7);
    check("R3 reversed key", {31'd0, cpu_stall_o}, 0);
    wr(2'd2, 32'h55); wr(2'd2, 32'h55); wr(2'd2, 32'hAA); wr(2'd1, 32'h7);
    check("R3 repeated 55h", {31'd0, cpu_stall_o}, 0);
    unlock(); wr(2'd2, 32'h55); wr(2'd1, 32'h7);
    check("R3 write after armed", {31'd0, cpu_stall_o}, 0);
    // R5 unlock consumed by a failed attempt
    unlock(); wr(2'd1, 32'h3);
    check("R4 esel clear no erase", {31'd0, cpu_stall_o}, 0);
    wr(2'd1, 32'h7);
    check("R5 unlock consumed", {31'd0, cpu_stall_o}, 0);
    // R8 error flag
    unlock(); wr(2'd1, 32'h5);
    rd(2'd1, d); check("R8 err set", d, 32'hC);
    check("R8 no erase", {31'd0, cpu_stall_o}, 0);
    unlock(); wr(2'd1, 32'h7);
    rd(2'd1, d); check("R8 err cleared", d, 32'h7);
    idle(CYC + 2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule